// File: doc/BRIEF.md
# Buffered Serial Byte Receiver

This block receives asynchronous serial frames of one start bit, eight data bits and one stop bit on a single input line. The line carries no clock, so the receiver waits in idle for a high-to-low transition. It confirms that the start bit is still low half a bit period later. It then takes every following bit at the centre of its bit period, using a tick counter whose terminal count comes from the clock-frequency and baud-rate parameters. Each new start edge realigns the bit timing.

Every correctly framed byte goes into a small internal first-in first-out queue. A parallel consumer sees a data-available flag whenever the queue holds at least one byte, reads the oldest byte on the data output, and removes it with a one-cycle read strobe. A frame whose stop bit reads low is thrown away and flagged with a one-cycle framing-error pulse. A good byte that arrives while the queue is full is also thrown away, and this is flagged with a one-cycle overrun pulse.

Top module: `uart_rx_fifo`

## Requirements
- R1: While reset is asserted and right after it is released, data_avail, frame_err and overrun are all 0.
- R2: A line held high produces no byte and no pulse.
- R3: Data bits are taken least significant bit first. With P the first rising clock edge after the line falls, a good byte is in the queue and data_avail is high after edge P+155 (16 clocks per bit at default parameters).
- R4: The start bit is checked at the middle of the start bit, and each later bit at the middle of its own bit period, both timed from the start edge. A bit boundary moved by up to a quarter bit does not change the byte.
- R5: If the line is high again at the mid-start check, the receiver goes back to idle with no byte and no pulse.
- R6: A stop bit that reads low discards the byte and raises frame_err for exactly one cycle, after edge P+154.
- R7: A good byte that arrives while the queue holds FIFO_DEPTH bytes is dropped. overrun is high for exactly one cycle after edge P+154, and the queued bytes are unchanged.
- R8: data_avail is high exactly when the queue is non-empty, and rd_data shows the oldest queued byte.
- R9: A rd_strobe while the queue is empty has no effect.
- R10: Bytes leave the queue in arrival order, including when a read and a write fall on the same edge.
- R11: The receiver realigns on every start edge, so a frame that starts right after the previous stop bit is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rd_strobe | input | 1 | Pops the oldest byte when the queue is non-empty |
| rd_data | output | 8 | Oldest queued byte |
| data_avail | output | 1 | Queue non-empty |
| frame_err | output | 1 | One-cycle pulse: stop bit read low |
| overrun | output | 1 | One-cycle pulse: byte dropped because the queue was full |

## Verification
The receive path is tried with several frame types:
- Alternating and irregular bit patterns show whether bits land in the right order.
- A frame whose bit edges are shifted by a quarter bit in alternate directions separates centre sampling from sampling near the edges.
- A low stop bit and a start pulse shorter than half a bit check the framing-error path and the glitch rejection.
- Frames sent back to back, with no idle time between them, check that timing realigns on each start edge.

On the queue side, one test fills it past its depth with no reads, and another reads continuously while frames arrive. Together these show that dropped bytes never displace stored ones, and that order holds when a read and a write share an edge.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RESET_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= RESET_VAL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxs_frame.sv
module rxs_frame
  import rxs_pkg::*;
#(
  parameter int BIT_TICKS = 16,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_s,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_vld,
  output logic              frame_err
);
  localparam int CNT_W = (BIT_TICKS > 1) ? $clog2(BIT_TICKS) : 1;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] HALF_C   = CNT_W'(BIT_TICKS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_C   = CNT_W'(BIT_TICKS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_t         st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [IDX_W-1:0]  idx, idx_n;
  logic [DATA_W-1:0] sh, sh_n;
  logic              rx_d;
  logic              vld_n, ferr_n;
  logic              fall;

  assign fall = rx_d & ~rx_s;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    idx_n  = idx;
    sh_n   = sh;
    vld_n  = 1'b0;
    ferr_n = 1'b0;
    case (st)
      ST_IDLE: begin
        if (fall) begin
          st_n  = ST_START;
          cnt_n = '0;
        end
      end
      ST_START: begin
        if (cnt == HALF_C) begin
          cnt_n = '0;
          idx_n = '0;
          st_n  = rx_s ? ST_IDLE : ST_DATA;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_DATA: begin
        if (cnt == LAST_C) begin
          cnt_n = '0;
          sh_n  = {rx_s, sh[DATA_W-1:1]};
          if (idx == IDX_LAST) st_n = ST_STOP;
          else                 idx_n = idx + 1'b1;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_STOP: begin
        if (cnt == LAST_C) begin
          cnt_n  = '0;
          st_n   = ST_IDLE;
          vld_n  = rx_s;
          ferr_n = ~rx_s;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      idx       <= '0;
      sh        <= '0;
      rx_d      <= 1'b1;
      byte_vld  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      idx       <= idx_n;
      sh        <= sh_n;
      rx_d      <= rx_s;
      byte_vld  <= vld_n;
      frame_err <= ferr_n;
    end
  end

  assign byte_o = sh;
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              not_empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [CW-1:0]     cnt, cnt_n;
  logic              wr_ok, rd_ok;

  assign full      = (cnt == DEPTH_C);
  assign not_empty = (cnt != '0);
  assign wr_ok     = wr_en & ~full;
  assign rd_ok     = rd_en & not_empty;

  always_comb begin
    cnt_n = cnt;
    case ({wr_ok, rd_ok})
      2'b10:   cnt_n = cnt + 1'b1;
      2'b01:   cnt_n = cnt - 1'b1;
      default: cnt_n = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      cnt <= cnt_n;
      if (wr_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
    end
  end

  assign rd_data = mem[rp];
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int CLK_HZ     = 40_000_000,
  parameter int BAUD       = 2_500_000,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_avail,
  output logic              frame_err,
  output logic              overrun
);
  localparam int BIT_TICKS = CLK_HZ / BAUD;

  logic              rst_i_n;
  logic              rx_s;
  logic [DATA_W-1:0] byte_w;
  logic              byte_vld;
  logic              q_full;

  rxs_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_i_n)
  );

  rxs_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_i_n), .d(rx_line), .q(rx_s)
  );

  rxs_frame #(.BIT_TICKS(BIT_TICKS), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_i_n), .rx_s(rx_s),
    .byte_o(byte_w), .byte_vld(byte_vld), .frame_err(frame_err)
  );

  rxs_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(byte_vld), .wr_data(byte_w),
    .rd_en(rd_strobe), .rd_data(rd_data),
    .not_empty(data_avail), .full(q_full)
  );

  assign overrun = byte_vld & q_full;
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_strobe,
  input logic [DATA_W-1:0] rd_data,
  input logic              data_avail,
  input logic              frame_err,
  input logic              overrun,
  input logic              byte_vld
);
  a_r6_ferr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  a_r7_ovr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);

  a_r7_ovr_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> data_avail);

  a_r6_no_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_err && overrun));

  a_r8_hold_avail: assert property (@(posedge clk) disable iff (!rst_n)
    (data_avail && !rd_strobe) |=> data_avail);

  a_r9_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_avail && !byte_vld) |=> !data_avail);

  a_r7_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !rd_strobe) |=> $stable(rd_data));
endmodule

bind uart_rx_fifo rxs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_data(rd_data),
  .data_avail(data_avail), .frame_err(frame_err), .overrun(overrun),
  .byte_vld(byte_vld)
);

// File: tb/uart_rx_fifo_test.sv
`timescale 1ns/1ps
module uart_rx_fifo_test;
  localparam int BIT   = 16;
  localparam int DEPTH = 4;
  localparam int LAT   = 155;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       rd_strobe = 1'b0;
  logic [7:0] rd_data;
  logic       data_avail, frame_err, overrun;

  int   cyc = 0;
  int   nchk = 0;
  int   nfail = 0;
  bit   active = 0;
  bit   done = 0;
  bit   pop_req = 0;
  string phase = "R1";

  bit       ev_on = 0;
  int       ev_t = 0;
  bit       ev_good = 0;
  logic [7:0] ev_byte = 8'h00;
  logic [7:0] q[$];

  uart_rx_fifo uut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .data_avail(data_avail), .frame_err(frame_err),
    .overrun(overrun)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s (phase %s) cyc=%0d got=%0h exp=%0h", tag, phase, cyc, got, exp);
    end
  endtask

  // Cycle-level reference model, compared on every falling edge
  always @(negedge clk) begin
    if (active) begin
      bit hit, exp_f, exp_o, do_push;
      hit   = ev_on && (cyc == ev_t);
      exp_f = hit && !ev_good;
      exp_o = hit && ev_good && (q.size() == DEPTH);
      chk({7'd0, data_avail}, {7'd0, q.size() != 0}, "R8 data_avail");
      if (q.size() != 0) chk(rd_data, q[0], "R3 R10 rd_data");
      chk({7'd0, frame_err}, {7'd0, exp_f}, "R6 frame_err");
      chk({7'd0, overrun},   {7'd0, exp_o}, "R7 overrun");
      do_push   = hit && ev_good && (q.size() < DEPTH);
      rd_strobe = pop_req;
      if (pop_req && q.size() != 0) void'(q.pop_front());
      if (do_push) q.push_back(ev_byte);
      if (hit) ev_on = 0;
    end
  end

  // skew: shift alternate bit edges by +/- a quarter bit (R4)
  task automatic send_frame(input logic [7:0] b, input bit stop_ok, input bit skew);
    logic [9:0] bits;
    bits = {stop_ok, b, 1'b0};
    @(negedge clk);
    ev_t = cyc + LAT; ev_good = stop_ok; ev_byte = b; ev_on = 1;
    for (int k = 0; k < 10; k++) begin
      int len;
      len = BIT;
      if (skew && k < 9) len = (k % 2 == 0) ? BIT + BIT/4 : BIT - BIT/4;
      if (skew && k == 9) len = BIT - BIT/4;
      rx_line = bits[k];
      if (k > 0) repeat (len) @(negedge clk);
      else repeat (len - 1) @(negedge clk);
    end
    rx_line = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic set_pop(input bit v);
    @(posedge clk); #1 pop_req = v;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk({7'd0, data_avail}, 8'd0, "R1 reset data_avail");
    chk({7'd0, frame_err}, 8'd0, "R1 reset frame_err");
    chk({7'd0, overrun},   8'd0, "R1 reset overrun");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({7'd0, data_avail}, 8'd0, "R1 after release");
    active = 1;

    phase = "R2"; idle(60);
    chk({7'd0, data_avail}, 8'd0, "R2 idle line");

    phase = "R3";
    send_frame(8'h55, 1, 0);
    send_frame(8'hA3, 1, 0);
    idle(BIT * 2);
    set_pop(1); idle(3); set_pop(0);

    phase = "R4";
    send_frame(8'hC6, 1, 1);
    idle(BIT * 2);
    set_pop(1); idle(2); set_pop(0);

    phase = "R9";
    set_pop(1); idle(10); set_pop(0);
    chk({7'd0, data_avail}, 8'd0, "R9 empty read");

    phase = "R5";
    @(negedge clk); rx_line = 1'b0;
    repeat (3) @(negedge clk); rx_line = 1'b1;
    idle(BIT * 12);
    chk({7'd0, data_avail}, 8'd0, "R5 glitch");

    phase = "R6";
    send_frame(8'h3C, 0, 0);
    idle(BIT * 2);
    chk({7'd0, data_avail}, 8'd0, "R6 discarded");

    phase = "R7";
    send_frame(8'h01, 1, 0);
    send_frame(8'h80, 1, 0);
    send_frame(8'h7E, 1, 0);
    send_frame(8'hFF, 1, 0);
    send_frame(8'hEE, 1, 0);
    idle(BIT * 2);
    set_pop(1); idle(6); set_pop(0);

    phase = "R11";
    send_frame(8'h00, 1, 0);
    send_frame(8'h96, 1, 0);
    send_frame(8'h5A, 1, 0);
    idle(BIT * 2);
    set_pop(1); idle(5); set_pop(0);

    phase = "R10";
    set_pop(1);
    send_frame(8'h12, 1, 0);
    send_frame(8'h34, 1, 0);
    idle(BIT * 2);
    set_pop(0);
    chk({7'd0, data_avail}, 8'd0, "R10 drained");

    idle(10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog phase %s", phase);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule